// File: doc/BRIEF.md
# Four-Lane Byte Interleaving Multiplexer

This block merges four byte-wide tributary lanes into a single byte stream that runs four times faster. Each lane byte arrives with a parity bit. A lane write strobe, synchronous to the fast clock, stands for one edge of that lane's own clock and pushes the byte into a shallow elastic FIFO for that lane. A slot counter divides the fast clock by four. It drives a lane-rate clock output, and it selects which lane is read in each fast cycle. Lane bytes leave in a fixed round-robin order, and the parity of each byte is checked as it leaves its FIFO.

The FIFO occupancy sets how long a byte waits, so a lane's parity error flag trails that byte's write by a varying number of lane cycles. An active-low synchronous realign input empties all four FIFOs and restarts the slot counter, so the four lanes line up again from lane A. A separate pulse input passes through one fast-clock register to an output.

Top module: `bimux_top`

## Requirements
- R1: `lane_clk` has a period of four fast clock cycles, with two cycles high and two cycles low. It is high in slots 0 and 1 of the slot counter, and the slot counter is 0 while either reset is active.
- R2: Each lane FIFO holds `FIFO_DEPTH` (default 8) entries. A lane write strobe that finds its FIFO full is dropped, and the bytes already held are kept in their order.
- R3: Reading starts only at the slot boundary after every lane holds at least `START_LEVEL` (default 2) entries. Until then `out_vld` stays 0.
- R4: Once reading has started, slot k reads lane k, in the order A=0, B=1, C=2, D=3, one slot per fast cycle. The first byte read comes from lane A. `out_lane` carries the index of the source lane. A slot whose lane FIFO is empty gives `out_vld`=0.
- R5: `out_byte` equals the lane byte unchanged. Bit 7 is the most significant bit and the first bit sent on the line; bit 0 is the last.
- R6: Parity is odd: a lane byte is good when its eight data bits and its parity bit hold an odd number of ones. `perr[i]` takes 1 for a bad byte and 0 for a good one in the same cycle that lane i's byte appears on `out_byte`. The flags of the other lanes keep their values.
- R7: While `sync_rst_n` is 0 at a clock edge, the block does all of the following: it empties every FIFO, returns the slot counter to 0, stops reading, and clears `out_vld` and `perr`. Data written before the realign is never output.
- R8: `read_out` equals `pulse_in` delayed by exactly one fast clock cycle.
- R9: When `rst_n` is 0, it asynchronously clears the same state as R7 and also clears `read_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast byte clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sync_rst_n | input | 1 | Synchronous lane realign, active low |
| lane_wr | input | 4 | Per-lane write strobe, one per lane clock edge (bit 0 = lane A) |
| lane_data | input | 32 | Lane bytes, lane i at bits [8i+7:8i] |
| lane_par | input | 4 | Odd parity bit of each lane byte |
| pulse_in | input | 1 | Pulse to re-register onto the fast clock |
| lane_clk | output | 1 | Lane-rate clock, fast clock divided by four |
| out_byte | output | 8 | Interleaved output byte, bit 7 sent first |
| out_vld | output | 1 | `out_byte` holds a lane byte this cycle |
| out_lane | output | 2 | Source lane of `out_byte` |
| perr | output | 4 | Per-lane parity error flag |
| read_out | output | 1 | `pulse_in` after one fast-clock register |

## Verification
The bench builds the block with its defaults: FIFO depth 8, start level 2, and four lanes of one byte each. With these values the stream runs steadily with one or two entries in each FIFO. A ten-write burst into one lane reaches the full condition and a dropped write. The start threshold can be held back by starving a single lane. Single-lane parity faults spread across the stream show that each flag follows only its own lane. A realign in the middle of a sequence shows that stale bytes are thrown away and that output restarts on lane A.

// File: rtl/bimux_pkg.sv
package bimux_pkg;
  localparam int LANES  = 4;
  localparam int SLOT_W = 2;

  typedef logic [SLOT_W-1:0] slot_t;

  // Advance the round-robin slot: A, B, C, D, then back to A.
  function automatic slot_t next_slot(input slot_t s);
    return (s == slot_t'(LANES - 1)) ? slot_t'(0) : s + slot_t'(1);
  endfunction

  // One-hot mask of a single lane.
  function automatic logic [LANES-1:0] lane_mask(input slot_t s);
    return LANES'(1) << s;
  endfunction
endpackage

// File: rtl/bimux_slot_gen.sv
module bimux_slot_gen
  import bimux_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sync_rst_n,
  output slot_t slot,
  output logic  slot_last,
  output logic  lane_clk
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           slot <= '0;
    else if (!sync_rst_n) slot <= '0;
    else                  slot <= next_slot(slot);
  end

  assign slot_last = (slot == slot_t'(LANES - 1));
  // High for the first half of each lane period.
  assign lane_clk  = (slot < slot_t'(LANES / 2));

  // R1: the slot counter wraps from the last slot to slot 0
  p_slot_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rst_n && slot_last) |=> (slot == '0));
  // R1: outside a realign the slot counter steps by one
  p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rst_n && !slot_last) |=> (slot == $past(slot) + slot_t'(1)));
  // R7: a realign returns the slot counter to 0
  p_slot_realign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_rst_n |=> (slot == '0));
endmodule

// File: rtl/bimux_lane_fifo.sv
module bimux_lane_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, do_wr, do_rd;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign do_wr = wr_en && !full && !clr;
  assign do_rd = rd_en && !empty && !clr;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_wr) wp <= ptr_inc(wp);
      if (do_rd) rp <= ptr_inc(rp);
      case ({do_wr, do_rd})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rp];

  // R2: occupancy never exceeds the depth
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R2: a write into a full FIFO without a read leaves it full, not wrapped
  p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && full && wr_en && !rd_en) |=> full);
  // R4: the reader never pops an empty FIFO
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);
  // R7: a clear empties the FIFO
  p_clr_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/bimux_merge.sv
module bimux_merge
  import bimux_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 run,
  input  slot_t                slot,
  input  logic [LANES-1:0]     empty,
  input  logic [LANES-1:0][W:0] heads,
  output logic [LANES-1:0]     rd_en,
  output logic [W-1:0]         out_byte,
  output logic                 out_vld,
  output slot_t                out_lane,
  output logic [LANES-1:0]     perr
);
  // Odd parity: the data bits plus the parity bit hold an odd count of ones.
  function automatic logic odd_parity_ok(input logic [W:0] v);
    return ^v;
  endfunction

  logic       take;
  logic [W:0] cur;
  logic       bad;

  assign cur  = heads[slot];
  assign take = run && !empty[slot];
  assign bad  = !odd_parity_ok(cur);
  assign rd_en = take ? lane_mask(slot) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0; out_byte <= '0; out_lane <= '0; perr <= '0;
    end else if (clr) begin
      out_vld <= 1'b0; out_byte <= '0; out_lane <= '0; perr <= '0;
    end else begin
      out_vld <= take;
      if (take) begin
        out_byte    <= cur[W-1:0];
        out_lane    <= slot;
        perr[slot]  <= bad;
      end
    end
  end

  // R3: no output byte unless reading was enabled
  p_start_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(run));
  // R4: back-to-back output bytes come from consecutive lanes
  p_lane_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(out_vld)) |-> (out_lane == next_slot($past(out_lane))));
  // R6: only the lane just output may change its error flag
  p_perr_own_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ((perr & ~lane_mask(out_lane)) == ($past(perr) & ~lane_mask(out_lane))));
  // R7: a realign clears the output and the flags
  p_realign_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!out_vld && (perr == '0)));
endmodule

// File: rtl/bimux_top.sv
module bimux_top
  import bimux_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 8,
  parameter int START_LEVEL = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_rst_n,
  input  logic [LANES-1:0]        lane_wr,
  input  logic [LANES*DATA_W-1:0] lane_data,
  input  logic [LANES-1:0]        lane_par,
  input  logic                    pulse_in,
  output logic                    lane_clk,
  output logic [DATA_W-1:0]       out_byte,
  output logic                    out_vld,
  output logic [SLOT_W-1:0]       out_lane,
  output logic [LANES-1:0]        perr,
  output logic                    read_out
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int ENT_W = DATA_W + 1;

  slot_t                    slot;
  logic                     slot_last;
  logic                     clr;
  logic                     run;
  logic [LANES-1:0]         ready;
  logic [LANES-1:0]         empty;
  logic [LANES-1:0]         rd_en;
  logic [LANES-1:0][DATA_W:0] heads;

  assign clr = !sync_rst_n;

  bimux_slot_gen u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_rst_n (sync_rst_n),
    .slot       (slot),
    .slot_last  (slot_last),
    .lane_clk   (lane_clk)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [CNT_W-1:0] cnt;
    bimux_lane_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .wr_en   (lane_wr[i]),
      .wr_data ({lane_par[i], lane_data[i*DATA_W +: DATA_W]}),
      .rd_en   (rd_en[i]),
      .rd_data (heads[i]),
      .count   (cnt),
      .empty   (empty[i])
    );
    assign ready[i] = (cnt >= CNT_W'(START_LEVEL));
  end

  // Reading starts on a slot boundary once every lane has its margin.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     run <= 1'b0;
    else if (clr)                   run <= 1'b0;
    else if (slot_last && (&ready)) run <= 1'b1;
  end

  bimux_merge #(.W(DATA_W)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .run      (run),
    .slot     (slot),
    .empty    (empty),
    .heads    (heads),
    .rd_en    (rd_en),
    .out_byte (out_byte),
    .out_vld  (out_vld),
    .out_lane (out_lane),
    .perr     (perr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) read_out <= 1'b0;
    else        read_out <= pulse_in;
  end

  // R3: reading begins only with every lane at its start level
  p_run_needs_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(&ready));
  // R4: the first read after a start is lane A
  p_first_slot_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (slot == '0));
  // R8: the pulse output is the input one cycle late
  p_pulse_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (read_out == $past(pulse_in)));
endmodule

// File: tb/tb_bimux_top.sv
`timescale 1ns/1ps
module tb_bimux_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_rst_n = 1'b1;
  logic [3:0]  lane_wr = '0;
  logic [31:0] lane_data = '0;
  logic [3:0]  lane_par = '0;
  logic        pulse_in = 1'b0;
  logic        lane_clk;
  logic [7:0]  out_byte;
  logic        out_vld;
  logic [1:0]  out_lane;
  logic [3:0]  perr;
  logic        read_out;

  always #2 clk = ~clk;

  bimux_top dut (
    .clk(clk), .rst_n(rst_n), .sync_rst_n(sync_rst_n), .lane_wr(lane_wr),
    .lane_data(lane_data), .lane_par(lane_par), .pulse_in(pulse_in),
    .lane_clk(lane_clk), .out_byte(out_byte), .out_vld(out_vld),
    .out_lane(out_lane), .perr(perr), .read_out(read_out)
  );

  // Row: {fault mask (bit0 = lane A), D, C, B, A}
  localparam int NROW = 12;
  localparam logic [35:0] TBL [NROW] = '{
    36'h0_D0_C0_B0_A0, 36'h0_D1_C1_B1_A1, 36'h0_7F_80_00_FF, 36'h1_D3_C3_B3_A3,
    36'h0_55_AA_0F_F0, 36'h0_D5_C5_B5_A5, 36'h4_D6_C6_B6_A6, 36'h0_01_02_04_08,
    36'h0_D8_C8_B8_A8, 36'h8_D9_C9_B9_A9, 36'h2_DA_CA_BA_AA, 36'h1_DB_CB_BB_AB
  };

  int n_chk = 0;
  int n_fail = 0;
  int rx_n = 0;
  logic [7:0] rx_data [64];
  logic [1:0] rx_lane [64];
  logic [3:0] rx_perr [64];

  always @(negedge clk) begin
    if (rst_n && out_vld && rx_n < 64) begin
      rx_data[rx_n] = out_byte;
      rx_lane[rx_n] = out_lane;
      rx_perr[rx_n] = perr;
      rx_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic push(input logic [3:0] en, input logic [31:0] d, input logic [3:0] flt);
    @(negedge clk);
    lane_wr = en;
    lane_data = d;
    for (int i = 0; i < 4; i++) lane_par[i] = (~^d[8*i +: 8]) ^ flt[i];
    @(negedge clk);
    lane_wr = '0;
  endtask

  task automatic realign;
    @(negedge clk);
    sync_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_vld && perr == 4'h0, "R7", "outputs during realign", {out_vld, perr}, 0);
    sync_rst_n = 1'b1;
    rx_n = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic s [8];
    logic [3:0] exp_perr;
    int na;
    logic [7:0] a_first, a_last;

    // R9: reset state
    repeat (3) @(negedge clk);
    chk(!out_vld && perr == 0 && !read_out, "R9", "reset state", {out_vld, perr, read_out}, 0);
    rst_n = 1'b1;

    // R1: lane clock shape
    for (int k = 0; k < 8; k++) begin
      s[k] = lane_clk;
      @(negedge clk);
    end
    for (int k = 0; k < 4; k++)
      chk(s[k] == s[k+4], "R1", "lane_clk period", s[k+4], s[k]);
    chk((int'(s[0]) + int'(s[1]) + int'(s[2]) + int'(s[3])) == 2, "R1", "lane_clk duty",
        int'(s[0]) + int'(s[1]) + int'(s[2]) + int'(s[3]), 2);

    // R8: pulse delay
    pulse_in = 1'b1;
    @(negedge clk);
    chk(read_out == 1'b1, "R8", "pulse high", read_out, 1);
    pulse_in = 1'b0;
    @(negedge clk);
    chk(read_out == 1'b0, "R8", "pulse low", read_out, 0);

    // Main stream: table walked by one loop
    rx_n = 0;
    for (int r = 0; r < NROW; r++) begin
      push(4'hF, TBL[r][31:0], TBL[r][35:32]);
      repeat (2) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    chk(rx_n == 4 * NROW, "R4", "stream byte count", rx_n, 4 * NROW);
    exp_perr = '0;
    for (int k = 0; k < 4 * NROW && k < rx_n; k++) begin
      chk(rx_lane[k] == 2'(k % 4), "R4", "lane order", rx_lane[k], k % 4);
      chk(rx_data[k] == TBL[k/4][8*(k%4) +: 8], "R5", "byte value", rx_data[k],
          TBL[k/4][8*(k%4) +: 8]);
      exp_perr[k%4] = TBL[k/4][32 + (k%4)];
      chk(rx_perr[k] == exp_perr, "R6", "parity flags", rx_perr[k], exp_perr);
    end
    chk(perr == 4'b0001, "R6", "flags after stream", perr, 4'b0001);

    // R7: realign clears flags
    realign();
    @(negedge clk);
    chk(perr == 4'h0, "R7", "flags after realign", perr, 0);

    // R3: start threshold
    push(4'hF, 32'h13121110, 4'h0);
    repeat (20) @(negedge clk);
    chk(rx_n == 0, "R3", "one entry per lane gives no output", rx_n, 0);
    push(4'h7, 32'h00232221, 4'h0);
    repeat (20) @(negedge clk);
    chk(rx_n == 0, "R3", "lane D short gives no output", rx_n, 0);
    push(4'h8, 32'h33000000, 4'h0);
    repeat (20) @(negedge clk);
    chk(rx_n == 8, "R3", "output after all lanes reach level", rx_n, 8);
    chk(rx_lane[0] == 2'd0 && rx_data[0] == 8'h10, "R4", "first byte from lane A",
        rx_data[0], 8'h10);
    chk(rx_data[7] == 8'h33, "R4", "last byte from lane D", rx_data[7], 8'h33);

    // R7: stale data flushed by realign
    realign();
    push(4'hF, 32'hEEEEEEEE, 4'h0);
    realign();
    push(4'hF, 32'h43424140, 4'h0);
    repeat (2) @(negedge clk);
    push(4'hF, 32'h53525150, 4'h0);
    repeat (20) @(negedge clk);
    chk(rx_n == 8, "R7", "only post-realign bytes", rx_n, 8);
    chk(rx_data[0] == 8'h40, "R7", "first byte after realign", rx_data[0], 8'h40);
    chk(rx_data[4] == 8'h50, "R7", "second lane A byte", rx_data[4], 8'h50);

    // R2: overflow of lane A drops writes 9 and 10
    realign();
    for (int k = 0; k < 10; k++) push(4'h1, {24'h0, 8'h60 + 8'(k)}, 4'h0);
    push(4'hE, 32'h71717100, 4'h0);
    push(4'hE, 32'h72727200, 4'h0);
    repeat (60) @(negedge clk);
    na = 0;
    a_first = '0;
    a_last = '0;
    for (int k = 0; k < rx_n; k++) begin
      if (rx_lane[k] == 2'd0) begin
        if (na == 0) a_first = rx_data[k];
        a_last = rx_data[k];
        na++;
      end
    end
    chk(na == 8, "R2", "lane A bytes kept", na, 8);
    chk(a_first == 8'h60, "R2", "lane A first byte", a_first, 8'h60);
    chk(a_last == 8'h67, "R2", "lane A last byte", a_last, 8'h67);
    chk(rx_n == 14, "R4", "empty slots give no output", rx_n, 14);

    summary();
    $finish;
  end
endmodule